// File: doc/BRIEF.md
# Folded-Word Numerically Controlled Oscillator

This block generates a variable-rate timebase from a fixed reference clock. A 16-bit control word is loaded through two byte writes, the high byte first and then the low byte. Before the word reaches the phase accumulator it is folded: codes below half-scale are used unchanged, and codes at or above half-scale are replaced by their 16-bit two's complement. The output rate is therefore symmetric around the midpoint code, and the largest effective step is 32768.

The accumulator adds the effective step once per reference cycle and wraps modulo 2^16. Every carry out of its top bit gives a one-cycle `tick`. The accumulator's top bit is driven out as a square wave (`sq_out`). Output rate = step × 2^-16 × f_ref. With the nominal 27 MHz reference, step 1 gives about 412 Hz. One instance serves one channel, and its outputs are the timebase for a downstream duty-cycle generator. While `start` is low the accumulator is held at zero.

Top module: `fold_nco`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `tick` and `sq_out` are 0.
- R2: With `start` high and effective step S, any run of N consecutive cycles in which N×S is a multiple of 65536 contains exactly N×S/65536 `tick` pulses.
- R3: A committed word W ≥ 0x8000 behaves exactly as step 65536−W. For example 0xD000 acts as 0x3000, 0xF000 as 0x1000, and 0x8000 as 0x8000.
- R4: When the effective step is a power of two, `sq_out` is high for exactly half the cycles of every whole output period.
- R5: A write with `wr_hi`=1 only stages the high byte and leaves the active word unchanged. A write with `wr_hi`=0 commits {staged high byte, written low byte} as the new word, so a half-written word never reaches the accumulator.
- R6: While `start` is low, the accumulator is held at 0 and `tick` and `sq_out` are 0. When `start` rises with step S, the first `tick` is seen on the 65536/S-th rising edge at which `start` is sampled high.
- R7: A committed word of 0 produces no `tick` and keeps `sq_out` low.
- R8: With word 0x8000, `tick` is high on every second cycle and `sq_out` toggles every cycle.
- R9: `tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Channel run enable; low holds the accumulator at zero |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 1: stage the high byte, 0: low byte and commit |
| wr_byte | input | 8 | Write data |
| tick | output | 1 | One-cycle pulse on each accumulator wrap |
| sq_out | output | 1 | Accumulator top bit (square wave) |

## Verification
The assertions assume that `wr_hi` carries meaning only when `wr_en` is high, and that `start` and the write pins are synchronous to `clk`. The bench changes every input on the falling edge and keeps `wr_en` high for exactly one cycle per byte. It checks rates only over windows whose length times the step is a whole multiple of 2^16. Because the expected tick count is then exact for any starting phase, a window can begin right after a word change without any realignment.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_WORD_W = 16;
  localparam int unsigned NCO_BYTE_W = NCO_WORD_W / 2;
  typedef logic [NCO_WORD_W-1:0] nco_word_t;
  typedef logic [NCO_BYTE_W-1:0] nco_byte_t;
endpackage

// File: rtl/nco_word_loader.sv
module nco_word_loader
  import nco_pkg::*;
#(
  parameter int unsigned WORD_W = NCO_WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [WORD_W/2-1:0] wr_byte,
  output logic [WORD_W-1:0]   word_q
);
  localparam int unsigned HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] hi_stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
      word_q     <= '0;
    end else if (wr_en) begin
      if (wr_hi) hi_stage_q <= wr_byte;
      else       word_q     <= {hi_stage_q, wr_byte};
    end
  end

  assert_hold_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> $stable(word_q));
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(word_q));
endmodule

// File: rtl/nco_fold.sv
module nco_fold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] step
);
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  always_comb begin
    if (word[WORD_W-1]) step = ~word + 1'b1;
    else                step = word;
  end

  assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step <= HALF);
  assert_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word < HALF) |-> (step == word));
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] step,
  output logic              tick,
  output logic              sq_out
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (!start) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= sum[WORD_W-1:0];
      tick  <= sum[WORD_W];
    end
  end

  assign sq_out = acc_q[WORD_W-1];

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start) |=> (acc_q == '0 && !tick && !sq_out));
  assert_single_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_zero_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && acc_q == '0) |=> (!tick && acc_q == '0));
endmodule

// File: rtl/fold_nco.sv
module fold_nco
  import nco_pkg::*;
#(
  parameter int unsigned WORD_W = NCO_WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [WORD_W/2-1:0] wr_byte,
  output logic                tick,
  output logic                sq_out
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] step;

  nco_word_loader #(.WORD_W(WORD_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_byte(wr_byte), .word_q(word_q)
  );

  nco_fold #(.WORD_W(WORD_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .word(word_q), .step(step)
  );

  nco_accum #(.WORD_W(WORD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .tick(tick), .sq_out(sq_out)
  );
endmodule

// File: tb/fold_nco_test.sv
module fold_nco_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       tick;
  logic       sq_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fold_nco uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_byte(wr_byte), .tick(tick), .sq_out(sq_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk); wr_en = 1; wr_hi = 1; wr_byte = w[15:8];
    @(negedge clk); wr_hi = 0; wr_byte = w[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic write_high(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_hi = 1; wr_byte = b;
    @(negedge clk); wr_en = 0; wr_hi = 0;
  endtask

  task automatic window(input int n, output int ticks, output int highs,
                        output int dbl, output int toggles);
    logic pt, ps;
    ticks = 0; highs = 0; dbl = 0; toggles = 0;
    @(negedge clk); pt = tick; ps = sq_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ticks += tick; highs += sq_out;
      if (tick && pt) dbl++;
      if (sq_out != ps) toggles++;
      pt = tick; ps = sq_out;
    end
  endtask

  task automatic t_reset;
    check("R1 tick in reset", tick, 0);
    check("R1 sq in reset", sq_out, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 tick after reset", tick, 0);
    check("R1 sq after reset", sq_out, 0);
  endtask

  task automatic t_rate;
    int t, h, d, g;
    write_word(16'h1000); start = 1;
    window(256, t, h, d, g);
    check("R2 ticks step 0x1000", t, 16);
    check("R4 highs step 0x1000", h, 128);
    write_word(16'h3000);
    window(64, t, h, d, g);
    check("R2 ticks step 0x3000", t, 12);
  endtask

  task automatic t_fold;
    int t, h, d, g;
    write_word(16'hD000);
    window(64, t, h, d, g);
    check("R3 ticks word 0xD000", t, 12);
    write_word(16'hF000);
    window(256, t, h, d, g);
    check("R3 ticks word 0xF000", t, 16);
    check("R4 highs word 0xF000", h, 128);
  endtask

  task automatic t_max;
    int t, h, d, g;
    write_word(16'h8000);
    window(64, t, h, d, g);
    check("R8 ticks word 0x8000", t, 32);
    check("R8 sq toggles word 0x8000", g, 64);
    check("R4 highs word 0x8000", h, 32);
    check("R9 consecutive ticks", d, 0);
  endtask

  task automatic t_torn;
    int t, h, d, g;
    write_word(16'h1000);
    write_high(8'h40);
    window(256, t, h, d, g);
    check("R5 high byte only keeps rate", t, 16);
    @(negedge clk); wr_en = 1; wr_hi = 0; wr_byte = 8'h00;
    @(negedge clk); wr_en = 0;
    window(64, t, h, d, g);
    check("R5 low byte commits 0x4000", t, 16);
  endtask

  task automatic t_idle;
    int bad = 0;
    write_word(16'h4000);
    @(negedge clk); start = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick || sq_out) bad++;
    end
    check("R6 outputs low while stopped", bad, 0);
    start = 1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R6 first tick from zero phase", tick, (i == 4) ? 1 : 0);
    end
  endtask

  task automatic t_zero;
    int t, h, d, g;
    write_word(16'h0000);
    @(negedge clk); start = 0;
    @(negedge clk); start = 1;
    window(100, t, h, d, g);
    check("R7 ticks word 0", t, 0);
    check("R7 highs word 0", h, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rate();
    t_fold();
    t_max();
    t_torn();
    t_idle();
    t_zero();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule